// File: doc/BRIEF.md
# Single-Bank DDR3 Command Scheduler

This block turns a stream of queued read and write requests into DDR3 commands for a half-rate PHY. It works only after memory initialization is complete. It takes requests in order from a show-ahead command FIFO. Each request word carries an op bit (1 = read, 0 = write), the bank, row and column, eight beats of write data and an 8-bit write mask.

At most one bank is open at any time. A request opens its row with an activate. The block then keeps issuing column commands for as long as the next queued request has the same op, bank and row. It closes the row with a precharge when one of these holds:

- the queue is empty,
- the op changes,
- the address changes,
- a refresh is due.

A free-running timer raises refresh requests, and these are served before any new activate. Each core cycle carries one command; the PHY fills the second memory-clock slot of the cycle with a deselect.

A read-valid pulse is produced by a shift register of programmable length. The register is loaded with a 1 every time a read leaves the block, so the pulse follows each read by a fixed number of cycles. All timing limits are parameters. Most are given in core cycles. The turnaround limits are derived from memory-clock latencies.

Top module: `ddr_single_bank_sched`

## Requirements
- R1: After reset `cmd_code` is 3'b111, and `req_pop` and `rd_valid` are low. Until `init_done` is seen high, no command other than 3'b111 is issued and nothing is popped, even with requests queued and a refresh due.
- R2: `cmd_code` holds {RAS_n,CAS_n,WE_n}. The codes are: refresh 3'b001, precharge 3'b010, activate 3'b011, write 3'b100, read 3'b101, no-op 3'b111.
- R3: Column commands take queue entries strictly in order. Each carries its entry's op, column, write data and mask. `req_pop` is high only in the cycle directly before that entry's column command appears, and never while the queue is empty.
- R4: Consecutive entries with the same op, bank and row are issued as column commands without a precharge or activate between them.
- R5: A precharge is issued only when one of these holds: the queue is empty, the head differs from the open row in op, bank or row, or a refresh is pending. In the last case the next non-no-op command is a refresh.
- R6: A pending refresh wins over the head request. No two refresh commands are more than REFI_CYC+40 cycles apart while requests keep arriving, and a refresh is issued only with the bank closed.
- R7: REFI_CYC = REFI_PS/CLK_PS − 10. With no traffic, refresh commands appear exactly REFI_CYC cycles apart.
- R8: These minimum spacings hold, in core cycles:
  - activate to column command: T_RCD
  - activate to precharge: T_RAS
  - precharge to activate or refresh: T_RP
  - refresh to any command: T_RFC
- R9: Column commands of the same type are at least 2 cycles apart (tCCD = 4 memory clocks). Read to write is at least (RL+4+2−WL+1)/2 cycles. Write to read is at least (WL+4+WTR_CK+1)/2 cycles.
- R10: Read to precharge is at least T_RTP cycles. Write to precharge is at least (WL+4+WR_CK+1)/2 cycles.
- R11: `cmd_addr[10]` is 0 on precharge, read and write, so only a single bank is closed and no auto-precharge is used. An activate carries the head's bank and row. Column commands carry the open bank and the column in the low address bits.
- R12: `rd_valid` is high for exactly one cycle, RD_DLY cycles after each read command appears on `cmd_code`, and at no other time.
- R13: At most one bank is open. An activate is issued only with the bank closed, and column and precharge commands target the open bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, half the memory clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Memory initialization finished |
| req_empty | input | 1 | Request queue empty |
| req_op | input | 1 | Head op: 1 read, 0 write |
| req_bank | input | BANK_W | Head bank |
| req_row | input | ROW_W | Head row |
| req_col | input | COL_W | Head column |
| req_wdata | input | 8*DQ_W | Head write data, eight beats |
| req_wmask | input | 8 | Head write mask, one bit per beat |
| req_pop | output | 1 | Advance the queue past the head |
| cmd_code | output | 3 | {RAS_n,CAS_n,WE_n} for this cycle |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | ROW_W | Command address |
| cmd_wdata | output | 8*DQ_W | Write data sent with a write |
| cmd_wmask | output | 8 | Write mask sent with a write |
| rd_valid | output | 1 | Read data valid pulse |

## Verification
A state register stuck in a column state, or a lost refresh flag, shows up as a refresh gap longer than the bound within a few hundred cycles. A wrong open-row register shows up at once as a column command whose address differs from the queue head. A wrong timing counter shows up at the very next command that depends on it: its spacing from the earlier command falls short. A wrong shift length puts `rd_valid` in the wrong cycle after the first read. An eager precharge shows up at the next command, which is not a refresh.

// File: rtl/ddr_single_bank_sched.sv
module ddr_single_bank_sched #(
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int COL_W   = 10,
  parameter int DQ_W    = 16,
  parameter int CLK_PS  = 6000,
  parameter int REFI_PS = 7800000,
  parameter int RL      = 6,
  parameter int WL      = 5,
  parameter int WTR_CK  = 4,
  parameter int WR_CK   = 6,
  parameter int T_RCD   = 3,
  parameter int T_RAS   = 6,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 27,
  parameter int T_RTP   = 2,
  parameter int RD_DLY  = 10
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_done,
  input  logic                req_empty,
  input  logic                req_op,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]    req_row,
  input  logic [COL_W-1:0]    req_col,
  input  logic [8*DQ_W-1:0]   req_wdata,
  input  logic [7:0]          req_wmask,
  output logic                req_pop,
  output logic [2:0]          cmd_code,
  output logic [BANK_W-1:0]   cmd_bank,
  output logic [ROW_W-1:0]    cmd_addr,
  output logic [8*DQ_W-1:0]   cmd_wdata,
  output logic [7:0]          cmd_wmask,
  output logic                rd_valid
);
  localparam int CCD_CK   = 4;
  localparam int BEATS    = 8;
  localparam int CCD_CYC  = CCD_CK / 2;
  localparam int RTW_CYC  = (RL + CCD_CK + 2 - WL + 1) / 2;
  localparam int WTR_CYC  = (WL + BEATS/2 + WTR_CK + 1) / 2;
  localparam int WRP_CYC  = (WL + BEATS/2 + WR_CK + 1) / 2;
  localparam int REFI_CYC = REFI_PS / CLK_PS - 10;
  localparam int TW = $clog2(T_RFC + T_RAS + T_RCD + T_RP + T_RTP + RTW_CYC + WTR_CYC + WRP_CYC + 2);
  localparam int RW = $clog2(REFI_CYC + 1);

  localparam logic [2:0] CMD_REFRESH = 3'b001;
  localparam logic [2:0] CMD_CLOSE   = 3'b010;
  localparam logic [2:0] CMD_OPEN    = 3'b011;
  localparam logic [2:0] CMD_WRITE   = 3'b100;
  localparam logic [2:0] CMD_READ    = 3'b101;
  localparam logic [2:0] CMD_NOP     = 3'b111;

  typedef enum logic [3:0] {
    ST_START, ST_MODE, ST_REFRESH, ST_CLOSE, ST_OPEN,
    ST_WRITE, ST_READ, ST_WAIT, ST_ZQ
  } sched_state_t;

  sched_state_t        state;
  logic [TW-1:0]       tmr, ras_cnt, ccd_cnt, pre_cnt, turn_cnt;
  logic [RW-1:0]       ref_cnt;
  logic                ref_pend, last_rd;
  logic [BANK_W-1:0]   open_bank;
  logic [ROW_W-1:0]    open_row;
  logic [RD_DLY-1:0]   rd_sr;

  wire in_col   = (state == ST_WRITE) || (state == ST_READ);
  wire cur_rd   = (state == ST_READ);
  wire head_hit = !req_empty && (req_op == cur_rd) && (req_bank == open_bank) && (req_row == open_row);
  wire turn_ok  = (cur_rd == last_rd) || (turn_cnt == '0);
  wire may_close = in_col && !(head_hit && !ref_pend) && (ras_cnt == '0) && (pre_cnt == '0);

  assign req_pop  = in_col && head_hit && !ref_pend && (ccd_cnt == '0) && turn_ok;
  assign rd_valid = rd_sr[RD_DLY-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_START;
      cmd_code  <= CMD_NOP;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      cmd_wmask <= '0;
      tmr       <= '0;
      ras_cnt   <= '0;
      ccd_cnt   <= '0;
      pre_cnt   <= '0;
      turn_cnt  <= '0;
      ref_cnt   <= '0;
      ref_pend  <= 1'b0;
      last_rd   <= 1'b0;
      open_bank <= '0;
      open_row  <= '0;
      rd_sr     <= '0;
    end else begin
      cmd_code <= CMD_NOP;
      if (tmr != '0)      tmr      <= tmr - 1'b1;
      if (ras_cnt != '0)  ras_cnt  <= ras_cnt - 1'b1;
      if (ccd_cnt != '0)  ccd_cnt  <= ccd_cnt - 1'b1;
      if (pre_cnt != '0)  pre_cnt  <= pre_cnt - 1'b1;
      if (turn_cnt != '0) turn_cnt <= turn_cnt - 1'b1;
      if (ref_cnt == RW'(REFI_CYC - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
      rd_sr <= (rd_sr << 1) | RD_DLY'(cmd_code == CMD_READ);

      case (state)
        ST_START: if (init_done) state <= ST_WAIT;
        ST_WAIT: if (tmr == '0) begin
          if (ref_pend) begin
            cmd_code <= CMD_REFRESH;
            cmd_addr <= '0;
            ref_pend <= 1'b0;
            tmr      <= TW'(T_RFC - 1);
            state    <= ST_REFRESH;
          end else if (!req_empty) begin
            cmd_code  <= CMD_OPEN;
            cmd_bank  <= req_bank;
            cmd_addr  <= req_row;
            open_bank <= req_bank;
            open_row  <= req_row;
            tmr       <= TW'(T_RCD - 1);
            ras_cnt   <= TW'(T_RAS - 1);
            state     <= ST_OPEN;
          end
        end
        ST_REFRESH, ST_CLOSE: if (tmr == '0) state <= ST_WAIT;
        ST_OPEN: if (tmr == '0) state <= req_op ? ST_READ : ST_WRITE;
        ST_WRITE, ST_READ: begin
          if (req_pop) begin
            cmd_code     <= cur_rd ? CMD_READ : CMD_WRITE;
            cmd_bank     <= open_bank;
            cmd_addr     <= ROW_W'(req_col);
            cmd_addr[10] <= 1'b0;
            cmd_wdata    <= req_wdata;
            cmd_wmask    <= req_wmask;
            ccd_cnt      <= TW'(CCD_CYC - 1);
            pre_cnt      <= cur_rd ? TW'(T_RTP - 1) : TW'(WRP_CYC - 1);
            turn_cnt     <= cur_rd ? TW'(RTW_CYC - 1) : TW'(WTR_CYC - 1);
            last_rd      <= cur_rd;
          end else if (may_close) begin
            cmd_code <= CMD_CLOSE;
            cmd_bank <= open_bank;
            cmd_addr <= '0;
            tmr      <= TW'(T_RP - 1);
            state    <= ST_CLOSE;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    req_pop |-> !req_empty); // R3
  AST_POP_THEN_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    req_pop |=> (cmd_code == CMD_READ || cmd_code == CMD_WRITE)); // R3
  AST_START_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START) |=> (cmd_code == CMD_NOP)); // R1
  AST_REFRESH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && tmr == '0 && ref_pend) |=> (cmd_code == CMD_REFRESH)); // R6
  AST_A10_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_CLOSE || cmd_code == CMD_READ || cmd_code == CMD_WRITE) |-> !cmd_addr[10]); // R11
  AST_CLOSE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_CLOSE) |-> (ras_cnt == '0)); // R8
endmodule

// File: tb/ddr_single_bank_sched_test.sv
module ddr_single_bank_sched_test;
  localparam int CLK_NS   = 10;
  localparam int P_CLK_PS = 10000;
  localparam int P_REFI   = 1500000;
  localparam int P_RL = 6, P_WL = 5, P_WTR_CK = 4, P_WR_CK = 6;
  localparam int P_RCD = 3, P_RAS = 7, P_RP = 3, P_RFC = 12, P_RTP = 2, P_DLY = 5;
  localparam int DQ = 4;
  localparam int E_REFI = P_REFI / P_CLK_PS - 10;
  localparam int E_RTW  = (P_RL + 4 + 2 - P_WL + 1) / 2;
  localparam int E_WTR  = (P_WL + 4 + P_WTR_CK + 1) / 2;
  localparam int E_WRP  = (P_WL + 4 + P_WR_CK + 1) / 2;
  localparam int E_CCD  = 2;

  logic clk = 0, rst_n = 0, init_done = 0;
  logic req_empty, req_op, req_pop, rd_valid;
  logic [2:0] req_bank, cmd_bank, cmd_code;
  logic [13:0] req_row, cmd_addr;
  logic [9:0] req_col;
  logic [8*DQ-1:0] req_wdata, cmd_wdata;
  logic [7:0] req_wmask, cmd_wmask;

  ddr_single_bank_sched #(.BANK_W(3), .ROW_W(14), .COL_W(10), .DQ_W(DQ), .CLK_PS(P_CLK_PS),
    .REFI_PS(P_REFI), .RL(P_RL), .WL(P_WL), .WTR_CK(P_WTR_CK), .WR_CK(P_WR_CK), .T_RCD(P_RCD),
    .T_RAS(P_RAS), .T_RP(P_RP), .T_RFC(P_RFC), .T_RTP(P_RTP), .RD_DLY(P_DLY)) uut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .req_empty(req_empty), .req_op(req_op),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .req_wmask(req_wmask), .req_pop(req_pop), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_wmask(cmd_wmask), .rd_valid(rd_valid));

  always #(CLK_NS/2) clk = ~clk;

  logic q_op [256];
  logic [2:0] q_bank [256];
  logic [13:0] q_row [256];
  logic [9:0] q_col [256];
  logic [8*DQ-1:0] q_data [256];
  logic [7:0] q_mask [256];
  int wp = 0, rp = 0, chk_idx = 0;
  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  assign req_empty = (wp == rp);
  assign req_op    = q_op[rp & 255];
  assign req_bank  = q_bank[rp & 255];
  assign req_row   = q_row[rp & 255];
  assign req_col   = q_col[rp & 255];
  assign req_wdata = q_data[rp & 255];
  assign req_wmask = q_mask[rp & 255];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && req_pop) rp <= rp + 1;
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(bit op, int bank, int row, int col);
    q_op[wp & 255]   = op;
    q_bank[wp & 255] = 3'(bank);
    q_row[wp & 255]  = 14'(row);
    q_col[wp & 255]  = 10'(col);
    q_data[wp & 255] = (8*DQ)'(wp * 32'h9E3779B1);
    q_mask[wp & 255] = 8'(wp * 7 + 3);
    wp = wp + 1;
  endtask

  // monitor state
  int last_act = -100000, last_pre = -100000, last_ref = -100000, last_rd = -100000;
  int last_wr = -100000, last_col = -100000, last_ref_q = -1, q_gaps = 0;
  int act_cnt = 0, ref_cnt = 0;
  bit is_open = 0, had_col = 0, col_op = 0, need_ref = 0, quiet = 0;
  logic [2:0] o_bank;
  logic [13:0] o_row;
  bit [63:0] vexp = '0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rd_valid == vexp[cyc % 64], "R12", "rd_valid", rd_valid, vexp[cyc % 64]);
      vexp[cyc % 64] = 1'b0;
      if (!init_done) begin
        chk(cmd_code == 3'b111, "R1", "cmd before init", cmd_code, 3'b111);
        chk(req_pop == 0, "R1", "pop before init", req_pop, 0);
      end
      if (need_ref && cmd_code != 3'b111) begin
        chk(cmd_code == 3'b001, "R5", "command after unforced close", cmd_code, 3'b001);
        need_ref = 0;
      end
      case (cmd_code)
        3'b011: begin
          chk(!is_open, "R13", "activate with bank open", is_open, 0);
          chk(cyc - last_pre >= P_RP, "R8", "precharge to activate", cyc - last_pre, P_RP);
          chk(cyc - last_ref >= P_RFC, "R8", "refresh to activate", cyc - last_ref, P_RFC);
          chk(cmd_bank == req_bank, "R11", "activate bank", cmd_bank, req_bank);
          chk(cmd_addr == req_row, "R11", "activate row", cmd_addr, req_row);
          is_open = 1; had_col = 0; o_bank = cmd_bank; o_row = cmd_addr;
          last_act = cyc; act_cnt++;
        end
        3'b010: begin
          bit just;
          chk(is_open, "R13", "precharge with bank closed", is_open, 1);
          chk(cmd_bank == o_bank, "R13", "precharge bank", cmd_bank, o_bank);
          chk(cmd_addr[10] == 0, "R11", "precharge A10", cmd_addr[10], 0);
          chk(cyc - last_act >= P_RAS, "R8", "activate to precharge", cyc - last_act, P_RAS);
          chk(cyc - last_rd >= P_RTP, "R10", "read to precharge", cyc - last_rd, P_RTP);
          chk(cyc - last_wr >= E_WRP, "R10", "write to precharge", cyc - last_wr, E_WRP);
          just = (wp == rp) || (req_bank != o_bank) || (req_row != o_row) ||
                 (had_col && (req_op != col_op));
          if (!just) need_ref = 1;
          is_open = 0; last_pre = cyc;
        end
        3'b001: begin
          chk(!is_open, "R6", "refresh with bank open", is_open, 0);
          chk(cyc - last_pre >= P_RP, "R8", "precharge to refresh", cyc - last_pre, P_RP);
          chk(cyc - last_ref >= P_RFC, "R8", "refresh to refresh", cyc - last_ref, P_RFC);
          if (last_ref >= 0)
            chk(cyc - last_ref <= E_REFI + 40, "R6", "refresh gap bound", cyc - last_ref, E_REFI + 40);
          if (quiet) begin
            if (last_ref_q >= 0) begin
              chk(cyc - last_ref_q == E_REFI, "R7", "idle refresh interval", cyc - last_ref_q, E_REFI);
              q_gaps++;
            end
            last_ref_q = cyc;
          end
          last_ref = cyc; ref_cnt++;
        end
        3'b101, 3'b100: begin
          bit rd;
          int k;
          rd = (cmd_code == 3'b101);
          k = chk_idx & 255;
          chk(is_open, "R13", "column with bank closed", is_open, 1);
          chk(cmd_bank == o_bank, "R13", "column bank", cmd_bank, o_bank);
          chk(cmd_addr[10] == 0, "R11", "column A10", cmd_addr[10], 0);
          chk(chk_idx < wp, "R3", "column without request", chk_idx, wp);
          chk(rd == q_op[k], "R3", "column op order", rd, q_op[k]);
          chk(o_bank == q_bank[k] && o_row == q_row[k], "R3", "column row order", o_row, q_row[k]);
          chk(cmd_addr[9:0] == q_col[k], "R11", "column address", cmd_addr[9:0], q_col[k]);
          chk(rp == chk_idx + 1, "R3", "pop precedes column", rp, chk_idx + 1);
          if (!rd) begin
            chk(cmd_wdata == q_data[k], "R3", "write data", cmd_wdata, q_data[k]);
            chk(cmd_wmask == q_mask[k], "R3", "write mask", cmd_wmask, q_mask[k]);
            chk(cyc - last_rd >= E_RTW, "R9", "read to write", cyc - last_rd, E_RTW);
            last_wr = cyc;
          end else begin
            chk(cyc - last_wr >= E_WTR, "R9", "write to read", cyc - last_wr, E_WTR);
            vexp[(cyc + P_DLY) % 64] = 1'b1;
            last_rd = cyc;
          end
          chk(cyc - last_act >= P_RCD, "R8", "activate to column", cyc - last_act, P_RCD);
          chk(cyc - last_col >= E_CCD, "R9", "column spacing", cyc - last_col, E_CCD);
          last_col = cyc; had_col = 1; col_op = rd; chk_idx++;
        end
        3'b111: ;
        default: chk(0, "R2", "illegal command code", cmd_code, 3'b111);
      endcase
    end
  end

  task automatic drain();
    while (chk_idx != wp) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    int a0, r0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_code == 3'b111, "R1", "reset command", cmd_code, 3'b111);
    chk(req_pop == 0, "R1", "reset pop", req_pop, 0);
    chk(rd_valid == 0, "R1", "reset rd_valid", rd_valid, 0);
    for (int i = 0; i < 3; i++) push(1, 1, 2, i * 8);
    repeat (2 * E_REFI + 20) @(negedge clk);
    chk(rp == 0, "R1", "queue untouched before init", rp, 0);
    init_done = 1;
    drain();

    // same-row reads stay open
    a0 = act_cnt; r0 = ref_cnt;
    for (int i = 0; i < 8; i++) push(1, 2, 5, i * 8);
    drain();
    chk(act_cnt - a0 >= 1 && act_cnt - a0 <= 1 + ref_cnt - r0, "R4", "activates for read run",
        act_cnt - a0, 1);

    // same-row writes stay open
    a0 = act_cnt; r0 = ref_cnt;
    for (int i = 0; i < 8; i++) push(0, 3, 9, i * 8);
    drain();
    chk(act_cnt - a0 >= 1 && act_cnt - a0 <= 1 + ref_cnt - r0, "R4", "activates for write run",
        act_cnt - a0, 1);

    // alternating op on one row
    a0 = act_cnt;
    for (int i = 0; i < 8; i++) push(i % 2 == 0, 0, 4, i * 8);
    drain();
    chk(act_cnt - a0 >= 8, "R5", "activates for op changes", act_cnt - a0, 8);

    // row change on every entry
    a0 = act_cnt;
    for (int i = 0; i < 6; i++) push(1, 0, 20 + i, 16);
    drain();
    chk(act_cnt - a0 >= 6, "R5", "activates for row changes", act_cnt - a0, 6);

    // bank change on every entry
    a0 = act_cnt;
    for (int i = 0; i < 4; i++) push(0, i, 7, 24);
    drain();
    chk(act_cnt - a0 >= 4, "R13", "activates for bank changes", act_cnt - a0, 4);

    // mixed sweep over two banks, two rows and both ops
    for (int i = 0; i < 80; i++) begin
      int h;
      h = (i * 73 + 19) ^ (i * i);
      push(((i / 3) % 2 == 1) ^ h[5], h[3], 5 + h[4], (i * 8) % 1024);
    end
    drain();
    chk(chk_idx == wp, "R3", "all requests served", chk_idx, wp);

    // quiet period refresh interval
    repeat (E_REFI + 60) @(negedge clk);
    quiet = 1;
    repeat (4 * E_REFI + 10) @(negedge clk);
    chk(q_gaps >= 3, "R7", "idle refresh count", q_gaps, 3);
    chk(need_ref == 0, "R5", "pending close reason", need_ref, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", chk_idx, wp);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule